// File: doc/BRIEF.md
# Fetch Skid Buffer with Squash

This block sits in the first stage of a multithreaded in-order pipeline. It issues instructions for one thread per cycle and gives each one the thread's next sequence number. It keeps a small in-order buffer for each thread. The buffer holds instructions that could not finish their stage work or could not be handed to the next stage. Each cycle the selected thread is examined through up to `SLOTS` issue slots. A buffered instruction at the buffer head is always serviced before any fresh instruction is created. The first slot that fails stops the cycle and blocks the thread. The thread stays blocked until an external unblock pulse arrives.

The surrounding control supplies three bits for each slot:
- whether at least one request was serviced for that slot;
- whether all of the slot's requests completed;
- whether the next stage accepted the instruction.

A squash request for a thread drops buffered instructions from the head while their sequence number is greater than the squash number. A memory-stall squash keeps the stalling instruction by moving the boundary up by one. Two free-running counters record cycles with and without processed work, and a registered flag marks an idle cycle.

Top module: `fetch_skid_stage`

## Requirements
- R1: After reset, every thread buffer is empty and no thread is blocked. Both cycle counters are zero, the idle flag is 0 and no slot output is valid.
- R2: With an empty buffer, each slot creates a fresh instruction. Fresh numbers are consecutive per thread and start at 1. A slot with both done and sent set drives `out_vld[k]` with its number on `out_seq[16k +: 16]` in the same cycle. The valid slots always form a contiguous run starting at slot 0.
- R3: A fresh instruction whose slot has done=0 or sent=0 is appended to the thread buffer. The thread becomes blocked from the next cycle. Later slots of that cycle are neither processed nor given a number.
- R4: A non-empty buffer supplies the instruction for the slot. On success the entry is popped, and the next slot moves on to the next entry or to a fresh instruction. On failure the entry stays in place, is not appended again, and the thread blocks.
- R5: A cycle request (`go`) for a blocked thread produces no valid output and changes no buffer state. An unblock pulse for that thread clears the block from the next cycle.
- R6: A cycle counts as processed when at least one processed slot has `slot_svc` set. A processed cycle increments `run_cnt` and clears `idle`. Any other cycle increments `idle_cnt` and sets `idle`.
- R7: A squash with number S for a thread removes head entries while the head number is greater than S. It stops at the first entry that is less than or equal to S, or when the buffer is empty. The thread's next fresh number is unchanged.
- R8: With `sq_mem`=1 the squash uses S+1 as its limit, so an entry numbered S+1 is kept.
- R9: A squash for the thread selected by `go` in the same cycle takes precedence: no slot is processed, only the squash changes the buffer, and the removal completes in that one cycle. A squash for another thread does not disturb the selected thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| go | input | 1 | Process the selected thread this cycle |
| go_tid | input | TID_W | Selected thread |
| slot_svc | input | SLOTS | Per slot: at least one request serviced |
| slot_done | input | SLOTS | Per slot: all requests completed |
| slot_sent | input | SLOTS | Per slot: next stage accepted the instruction |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TID_W | Thread to squash |
| sq_seq | input | SEQ_W | Squash number |
| sq_mem | input | 1 | Memory-stall variant (limit is number + 1) |
| unblk_valid | input | 1 | Unblock request |
| unblk_tid | input | TID_W | Thread to unblock |
| out_vld | output | SLOTS | Slot instruction passed to the next stage |
| out_seq | output | SLOTS*SEQ_W | Sequence number per slot, slot k at bits 16k+15:16k |
| blocked | output | THREADS | Per-thread blocked state |
| buf_empty | output | THREADS | Per-thread buffer empty |
| head_seq | output | THREADS*SEQ_W | Head entry number per thread (valid when not empty) |
| run_cnt | output | CNT_W | Cycles with processed work |
| idle_cnt | output | CNT_W | Cycles without processed work |
| idle | output | 1 | Last cycle had no processed work |

## Verification
The bench targets these corners of the block's own behaviour:

- A squash limit equal to the head number must keep the entry. Using the wrong comparison drops an instruction that must survive.
- A memory-stall squash must keep the stalling entry, which an unshifted limit would remove.
- A squash that coincides with `go` for the same thread must win. A design that lets both act would pop an entry twice or issue an instruction that is being discarded.
- A head entry that fails must not be appended again, a failing slot must not consume numbers for later slots, and a blocked thread must stay quiet until unblocked.
- Sent instructions with no serviced request still count as an idle cycle.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  parameter int unsigned SEQ_W = 16;
  typedef logic [SEQ_W-1:0] seq_t;
endpackage

// File: rtl/fsk_thread_buf.sv
module fsk_thread_buf
  import fsk_pkg::*;
#(
  parameter int unsigned DEPTH  = 2,
  parameter int unsigned PEEK_N = 2,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sq_en,
  input  seq_t                         sq_lim,
  input  logic [CW-1:0]                pop_n,
  input  logic                         push,
  input  seq_t                         push_seq,
  output logic [CW-1:0]                count,
  output logic [PEEK_N-1:0][SEQ_W-1:0] peek,
  output logic                         empty
);
  seq_t              mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, rd_ptr_nx;
  logic [CW-1:0]     cnt_nx;
  logic [CW-1:0]     drop_n;
  logic [PTR_W-1:0]  wr_idx;
  logic              wr_en;

  // leading run of entries younger than the squash limit
  always_comb begin
    logic run;
    run    = 1'b1;
    drop_n = '0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (run && (i < int'(count)) && (mem[PTR_W'(rd_ptr + PTR_W'(i))] > sq_lim))
        drop_n = drop_n + 1'b1;
      else
        run = 1'b0;
    end
  end

  always_comb begin
    for (int k = 0; k < int'(PEEK_N); k++)
      peek[k] = mem[PTR_W'(rd_ptr + PTR_W'(k))];
  end

  assign wr_idx = PTR_W'(rd_ptr + PTR_W'(count));
  assign empty  = (count == '0);

  always_comb begin
    rd_ptr_nx = rd_ptr;
    cnt_nx    = count;
    wr_en     = 1'b0;
    if (sq_en) begin
      rd_ptr_nx = PTR_W'(rd_ptr + PTR_W'(drop_n));
      cnt_nx    = count - drop_n;
    end else begin
      wr_en     = push && (count - pop_n < CW'(DEPTH));
      rd_ptr_nx = PTR_W'(rd_ptr + PTR_W'(pop_n));
      cnt_nx    = count - pop_n + CW'(wr_en);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= rd_ptr_nx;
      count  <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= push_seq;
  end
endmodule

// File: rtl/fsk_slot_engine.sv
module fsk_slot_engine
  import fsk_pkg::*;
#(
  parameter int unsigned SLOTS = 2,
  parameter int unsigned DEPTH = 2,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned NW   = $clog2(SLOTS + 1)
) (
  input  logic                        en,
  input  logic [CW-1:0]               buf_cnt,
  input  logic [SLOTS-1:0][SEQ_W-1:0] peek,
  input  seq_t                        next_seq,
  input  logic [SLOTS-1:0]            svc,
  input  logic [SLOTS-1:0]            done,
  input  logic [SLOTS-1:0]            sent,
  output logic [CW-1:0]               pop_n,
  output logic                        push,
  output seq_t                        push_seq,
  output logic [NW-1:0]               new_n,
  output logic                        block,
  output logic [SLOTS-1:0]            out_vld,
  output logic [SLOTS-1:0][SEQ_W-1:0] out_seq,
  output logic [NW-1:0]               n_proc
);
  always_comb begin
    int   pops, news, procd;
    logic active, from_buf;
    seq_t s;
    pops     = 0;
    news     = 0;
    procd    = 0;
    active   = en;
    push     = 1'b0;
    push_seq = '0;
    block    = 1'b0;
    out_vld  = '0;
    out_seq  = '0;
    for (int k = 0; k < int'(SLOTS); k++) begin
      from_buf = (int'(buf_cnt) > pops);
      s        = from_buf ? seq_t'(peek[pops]) : seq_t'(next_seq + SEQ_W'(news));
      if (active) begin
        out_seq[k] = s;
        if (svc[k]) procd++;
        if (done[k] && sent[k]) begin
          out_vld[k] = 1'b1;
          if (from_buf) pops++;
          else          news++;
        end else begin
          if (!from_buf) begin
            push     = 1'b1;
            push_seq = s;
            news++;
          end
          block  = 1'b1;
          active = 1'b0;
        end
      end
    end
    pop_n  = CW'(pops);
    new_n  = NW'(news);
    n_proc = NW'(procd);
  end
endmodule

// File: rtl/fsk_cycle_stats.sv
module fsk_cycle_stats #(
  parameter int unsigned SLOTS = 2,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned NW   = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NW-1:0]    n_proc,
  output logic [CNT_W-1:0] run_cnt,
  output logic [CNT_W-1:0] idle_cnt,
  output logic             idle
);
  logic             worked;
  logic [CNT_W-1:0] run_nx, idle_cnt_nx;

  assign worked      = (n_proc != '0);
  assign run_nx      = worked ? run_cnt + 1'b1 : run_cnt;
  assign idle_cnt_nx = worked ? idle_cnt : idle_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      idle_cnt <= '0;
      idle     <= 1'b0;
    end else begin
      run_cnt  <= run_nx;
      idle_cnt <= idle_cnt_nx;
      idle     <= !worked;
    end
  end
endmodule

// File: rtl/fetch_skid_stage.sv
module fetch_skid_stage
  import fsk_pkg::*;
#(
  parameter int unsigned THREADS = 2,
  parameter int unsigned SLOTS   = 2,
  parameter int unsigned DEPTH   = 2,
  parameter int unsigned CNT_W   = 16,
  localparam int unsigned TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int unsigned CW     = $clog2(DEPTH + 1),
  localparam int unsigned NW     = $clog2(SLOTS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go,
  input  logic [TID_W-1:0]         go_tid,
  input  logic [SLOTS-1:0]         slot_svc,
  input  logic [SLOTS-1:0]         slot_done,
  input  logic [SLOTS-1:0]         slot_sent,
  input  logic                     sq_valid,
  input  logic [TID_W-1:0]         sq_tid,
  input  logic [SEQ_W-1:0]         sq_seq,
  input  logic                     sq_mem,
  input  logic                     unblk_valid,
  input  logic [TID_W-1:0]         unblk_tid,
  output logic [SLOTS-1:0]         out_vld,
  output logic [SLOTS*SEQ_W-1:0]   out_seq,
  output logic [THREADS-1:0]       blocked,
  output logic [THREADS-1:0]       buf_empty,
  output logic [THREADS*SEQ_W-1:0] head_seq,
  output logic [CNT_W-1:0]         run_cnt,
  output logic [CNT_W-1:0]         idle_cnt,
  output logic                     idle
);
  seq_t                        sq_lim;
  logic                        sel_blocked, sel_squashed, proc_en;
  logic [CW-1:0]               sel_cnt;
  logic [SLOTS-1:0][SEQ_W-1:0] sel_peek;
  seq_t                        sel_next;

  logic [CW-1:0]               eng_pop;
  logic                        eng_push, eng_block;
  seq_t                        eng_push_seq;
  logic [NW-1:0]               eng_new, eng_proc;
  logic [SLOTS-1:0][SEQ_W-1:0] eng_seq;

  logic [THREADS-1:0][CW-1:0]               t_cnt;
  logic [THREADS-1:0][SLOTS-1:0][SEQ_W-1:0] t_peek;
  seq_t                                     t_next    [THREADS];
  seq_t                                     t_next_nx [THREADS];
  logic [THREADS-1:0]                       blocked_nx;

  assign sq_lim       = sq_mem ? seq_t'(sq_seq + 1'b1) : sq_seq;
  assign sel_squashed = sq_valid && (sq_tid == go_tid);

  // thread mux for the engine
  always_comb begin
    sel_blocked = 1'b0;
    sel_cnt     = '0;
    sel_peek    = '0;
    sel_next    = '0;
    for (int t = 0; t < int'(THREADS); t++) begin
      if (go_tid == TID_W'(t)) begin
        sel_blocked = blocked[t];
        sel_cnt     = t_cnt[t];
        sel_peek    = t_peek[t];
        sel_next    = t_next[t];
      end
    end
  end

  assign proc_en = go && !sel_blocked && !sel_squashed;

  fsk_slot_engine #(.SLOTS(SLOTS), .DEPTH(DEPTH)) u_eng (
    .en       (proc_en),
    .buf_cnt  (sel_cnt),
    .peek     (sel_peek),
    .next_seq (sel_next),
    .svc      (slot_svc),
    .done     (slot_done),
    .sent     (slot_sent),
    .pop_n    (eng_pop),
    .push     (eng_push),
    .push_seq (eng_push_seq),
    .new_n    (eng_new),
    .block    (eng_block),
    .out_vld  (out_vld),
    .out_seq  (eng_seq),
    .n_proc   (eng_proc)
  );

  assign out_seq = eng_seq;

  generate
    for (genvar t = 0; t < THREADS; t++) begin : g_thr
      logic          mine;
      logic [CW-1:0] pop_t;
      logic          push_t;
      logic [SLOTS-1:0][SEQ_W-1:0] pk;

      assign mine   = proc_en && (go_tid == TID_W'(t));
      assign pop_t  = mine ? eng_pop : '0;
      assign push_t = mine && eng_push;

      fsk_thread_buf #(.DEPTH(DEPTH), .PEEK_N(SLOTS)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .sq_en    (sq_valid && (sq_tid == TID_W'(t))),
        .sq_lim   (sq_lim),
        .pop_n    (pop_t),
        .push     (push_t),
        .push_seq (eng_push_seq),
        .count    (t_cnt[t]),
        .peek     (pk),
        .empty    (buf_empty[t])
      );

      assign t_peek[t] = pk;
      assign head_seq[t*SEQ_W +: SEQ_W] = pk[0];

      always_comb begin
        t_next_nx[t]  = mine ? seq_t'(t_next[t] + SEQ_W'(eng_new)) : t_next[t];
        blocked_nx[t] = blocked[t];
        if (unblk_valid && (unblk_tid == TID_W'(t))) blocked_nx[t] = 1'b0;
        if (mine && eng_block)                       blocked_nx[t] = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          t_next[t]  <= seq_t'(1);
          blocked[t] <= 1'b0;
        end else begin
          t_next[t]  <= t_next_nx[t];
          blocked[t] <= blocked_nx[t];
        end
      end
    end
  endgenerate

  fsk_cycle_stats #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_stats (
    .clk      (clk),
    .rst_n    (rst_n),
    .n_proc   (eng_proc),
    .run_cnt  (run_cnt),
    .idle_cnt (idle_cnt),
    .idle     (idle)
  );
endmodule

// File: rtl/fsk_checker.sv
module fsk_checker #(
  parameter int unsigned THREADS = 2,
  parameter int unsigned SLOTS   = 2,
  parameter int unsigned CNT_W   = 16,
  localparam int unsigned TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               go,
  input logic [TID_W-1:0]   go_tid,
  input logic [SLOTS-1:0]   slot_done,
  input logic               sq_valid,
  input logic [TID_W-1:0]   sq_tid,
  input logic [SLOTS-1:0]   out_vld,
  input logic [THREADS-1:0] blocked,
  input logic [THREADS-1:0] buf_empty,
  input logic [CNT_W-1:0]   run_cnt,
  input logic [CNT_W-1:0]   idle_cnt,
  input logic               idle
);
  // R2
  vld_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_vld & (out_vld + 1'b1)) == '0));

  // R5
  blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && blocked[go_tid]) |-> (out_vld == '0));

  // R9
  squash_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && sq_valid && (sq_tid == go_tid)) |-> (out_vld == '0));

  // R3
  block_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !blocked[go_tid] && !(sq_valid && (sq_tid == go_tid)) &&
     buf_empty[go_tid] && !slot_done[0]) |=> blocked[$past(go_tid)]);

  // R6
  one_counter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((run_cnt != $past(run_cnt)) != (idle_cnt != $past(idle_cnt))));

  // R6
  idle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> (idle_cnt != $past(idle_cnt)));
endmodule

bind fetch_skid_stage fsk_checker #(.THREADS(THREADS), .SLOTS(SLOTS), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .go        (go),
  .go_tid    (go_tid),
  .slot_done (slot_done),
  .sq_valid  (sq_valid),
  .sq_tid    (sq_tid),
  .out_vld   (out_vld),
  .blocked   (blocked),
  .buf_empty (buf_empty),
  .run_cnt   (run_cnt),
  .idle_cnt  (idle_cnt),
  .idle      (idle)
);

// File: tb/fetch_skid_stage_test.sv
module fetch_skid_stage_test;
  logic        clk, rst_n;
  logic        go, go_tid;
  logic [1:0]  slot_svc, slot_done, slot_sent;
  logic        sq_valid, sq_tid, sq_mem;
  logic [15:0] sq_seq;
  logic        unblk_valid, unblk_tid;
  logic [1:0]  out_vld;
  logic [31:0] out_seq;
  logic [1:0]  blocked, buf_empty;
  logic [31:0] head_seq;
  logic [15:0] run_cnt, idle_cnt;
  logic        idle;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [1:0]  vld;
    logic [15:0] s0;
    logic [15:0] s1;
    string       tag;
  } exp_t;
  exp_t sb[$];

  fetch_skid_stage uut (
    .clk(clk), .rst_n(rst_n), .go(go), .go_tid(go_tid),
    .slot_svc(slot_svc), .slot_done(slot_done), .slot_sent(slot_sent),
    .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq), .sq_mem(sq_mem),
    .unblk_valid(unblk_valid), .unblk_tid(unblk_tid),
    .out_vld(out_vld), .out_seq(out_seq), .blocked(blocked),
    .buf_empty(buf_empty), .head_seq(head_seq),
    .run_cnt(run_cnt), .idle_cnt(idle_cnt), .idle(idle)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compares slot outputs mid-cycle against queued expectations
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({e.tag, " out_vld"}, 32'(out_vld), 32'(e.vld));
      if (e.vld[0]) check({e.tag, " slot0 seq"}, 32'(out_seq[15:0]), 32'(e.s0));
      if (e.vld[1]) check({e.tag, " slot1 seq"}, 32'(out_seq[31:16]), 32'(e.s1));
    end
  end

  task automatic clear_in();
    go = 0; go_tid = 0; slot_svc = 0; slot_done = 0; slot_sent = 0;
    sq_valid = 0; sq_tid = 0; sq_seq = 0; sq_mem = 0;
    unblk_valid = 0; unblk_tid = 0;
  endtask

  // driver: applies one cycle and queues the expected slot outputs
  task automatic cyc(input logic g, input logic tid, input logic [1:0] svc,
                     input logic [1:0] dn, input logic [1:0] snt,
                     input logic sqv, input logic sqt, input logic [15:0] sqs,
                     input logic sqm, input logic [1:0] ev,
                     input logic [15:0] e0, input logic [15:0] e1, input string tag);
    exp_t e;
    go = g; go_tid = tid; slot_svc = svc; slot_done = dn; slot_sent = snt;
    sq_valid = sqv; sq_tid = sqt; sq_seq = sqs; sq_mem = sqm;
    e.vld = ev; e.s0 = e0; e.s1 = e1; e.tag = tag;
    sb.push_back(e);
    @(posedge clk); #1;
    clear_in();
  endtask

  task automatic squash(input logic tid, input logic [15:0] s, input logic m);
    sq_valid = 1; sq_tid = tid; sq_seq = s; sq_mem = m;
    @(posedge clk); #1;
    clear_in();
  endtask

  task automatic unblock(input logic tid);
    unblk_valid = 1; unblk_tid = tid;
    @(posedge clk); #1;
    clear_in();
  endtask

  task automatic idle_cycle();
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r0, i0;
    clear_in();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    check("R1 buf_empty", 32'(buf_empty), 32'h3);
    check("R1 blocked", 32'(blocked), 32'h0);
    check("R1 idle", 32'(idle), 32'h0);
    check("R1 out_vld", 32'(out_vld), 32'h0);
    check("R1 counters", {run_cnt, idle_cnt}, 32'h0);

    // R2 fresh numbering per thread
    cyc(1, 0, 2'b11, 2'b11, 2'b11, 0, 0, 0, 0, 2'b11, 1, 2, "R2 t0 first");
    cyc(1, 1, 2'b11, 2'b11, 2'b11, 0, 0, 0, 0, 2'b11, 1, 2, "R2 t1 first");
    cyc(1, 0, 2'b11, 2'b11, 2'b11, 0, 0, 0, 0, 2'b11, 3, 4, "R2 t0 second");

    // R6 cycle accounting
    r0 = run_cnt; i0 = idle_cnt;
    idle_cycle();
    check("R6 idle count", 32'(idle_cnt), 32'(i0 + 1));
    check("R6 idle flag", 32'(idle), 32'h1);
    cyc(1, 1, 2'b01, 2'b11, 2'b11, 0, 0, 0, 0, 2'b11, 3, 4, "R6 run cycle");
    check("R6 run count", 32'(run_cnt), 32'(r0 + 1));
    check("R6 idle clears", 32'(idle), 32'h0);
    cyc(1, 1, 2'b00, 2'b11, 2'b11, 0, 0, 0, 0, 2'b11, 5, 6, "R6 no service");
    check("R6 unserviced is idle", 32'(idle_cnt), 32'(i0 + 2));
    check("R6 idle flag again", 32'(idle), 32'h1);

    // R3 failing fresh instruction in slot 1
    cyc(1, 0, 2'b11, 2'b01, 2'b11, 0, 0, 0, 0, 2'b01, 5, 0, "R3 slot1 fail");
    check("R3 blocked", 32'(blocked), 32'h1);
    check("R3 buffered", 32'(buf_empty[0]), 32'h0);
    check("R3 head seq", 32'(head_seq[15:0]), 32'd6);

    // R5 blocked thread is quiet
    cyc(1, 0, 2'b11, 2'b11, 2'b11, 0, 0, 0, 0, 2'b00, 0, 0, "R5 blocked go");
    check("R5 buffer untouched", 32'(head_seq[15:0]), 32'd6);
    unblock(0);
    check("R5 unblocked", 32'(blocked), 32'h0);

    // R4 head first then fresh
    cyc(1, 0, 2'b11, 2'b11, 2'b11, 0, 0, 0, 0, 2'b11, 6, 7, "R4 head then fresh");
    check("R4 popped", 32'(buf_empty[0]), 32'h1);

    // R3 not-sent failure in slot 0: slot 1 gets no number
    cyc(1, 0, 2'b11, 2'b11, 2'b10, 0, 0, 0, 0, 2'b00, 0, 0, "R3 slot0 not sent");
    check("R3 head 8", 32'(head_seq[15:0]), 32'd8);
    unblock(0);

    // R4 failing head is kept and not appended again
    cyc(1, 0, 2'b11, 2'b00, 2'b11, 0, 0, 0, 0, 2'b00, 0, 0, "R4 head fail");
    check("R4 head kept", 32'(head_seq[15:0]), 32'd8);
    check("R4 blocked again", 32'(blocked), 32'h1);
    unblock(0);

    // R7 squash boundary
    squash(0, 16'd8, 0);
    check("R7 equal kept", 32'(buf_empty[0]), 32'h0);
    squash(0, 16'd7, 0);
    check("R7 younger removed", 32'(buf_empty[0]), 32'h1);
    cyc(1, 0, 2'b11, 2'b11, 2'b11, 0, 0, 0, 0, 2'b11, 9, 10, "R7 numbering unchanged");

    // R8 memory-stall squash
    cyc(1, 0, 2'b11, 2'b10, 2'b11, 0, 0, 0, 0, 2'b00, 0, 0, "R8 setup");
    squash(0, 16'd10, 1);
    check("R8 stalling kept", 32'(head_seq[15:0]), 32'd11);
    check("R8 not empty", 32'(buf_empty[0]), 32'h0);
    squash(0, 16'd9, 1);
    check("R8 removed", 32'(buf_empty[0]), 32'h1);
    unblock(0);

    // R9 squash on same thread wins
    cyc(1, 1, 2'b11, 2'b10, 2'b11, 0, 0, 0, 0, 2'b00, 0, 0, "R9 setup");
    check("R9 t1 head", 32'(head_seq[31:16]), 32'd7);
    unblock(1);
    cyc(1, 1, 2'b11, 2'b11, 2'b11, 1, 1, 16'd6, 0, 2'b00, 0, 0, "R9 squash wins");
    check("R9 removed", 32'(buf_empty[1]), 32'h1);
    check("R9 not blocked", 32'(blocked), 32'h0);
    squash(1, 16'd0, 0);
    check("R7 empty squash", 32'(buf_empty[1]), 32'h1);
    cyc(1, 1, 2'b11, 2'b11, 2'b11, 0, 0, 0, 0, 2'b11, 8, 9, "R9 after squash");
    cyc(1, 0, 2'b11, 2'b11, 2'b11, 1, 1, 16'd0, 0, 2'b11, 12, 13, "R9 other thread");

    idle_cycle();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule